// File: doc/BRIEF.md
# Circular Fault Event Logger

The block keeps a short history of fault events in a seven-slot on-chip log. Each slot holds an event code, a relative timestamp and a valid flag. Timestamps come from a free-running counter that starts at zero when reset is released and stops at its largest value instead of wrapping. A write pointer names the slot that the next event will fill. The host reads any slot and the pointer through a plain combinational read port.

Event sources raise one-cycle requests on `evt_i`. Source k is logged with code k+1. Requests that arrive together are parked in a pending register and logged one per cycle, lowest source index first. An event is stored only if the slot under the pointer is free. The pointer then moves on by one and wraps from the last slot to slot 0. If the slot is still occupied, the event is discarded and the pointer stays where it is, so occupied slots are never overwritten. The host empties the log with a one-cycle clear command, which invalidates every slot and returns the pointer to 0.

Top module: `fault_event_log`

## Requirements
- R1: After reset the pointer reads 0 and every slot reads back with valid 0, code 0 and timestamp 0.
- R2: An event that source k raises in a cycle with no other pending work is written into the slot under the pointer at the next clock edge. The slot then has valid 1, code k+1, and the timestamp equal to the number of clock edges since reset release that came before that edge.
- R3: Each stored event advances the pointer by one. From slot 6 the pointer returns to 0.
- R4: When the slot under the pointer is valid, an event is discarded. The pointer and all slot contents stay unchanged, and a slot's valid flag never clears except by the clear command.
- R5: Events raised in the same cycle are stored one per clock edge in consecutive cycles, in ascending source index order.
- R6: A clear (`clr_i` = 1 at an edge) leaves every slot invalid and the pointer at 0 after that edge. An event raised in the same cycle is held and stored in slot 0 at the following edge.
- R7: The timestamp counter stops at 2^TS_W-1 (255 by default). Events stored after that point carry that value.
- R8: A read index outside 0..6 returns valid 0, code 0 and timestamp 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Event requests, one bit per source, bit 0 has the highest priority |
| clr_i | input | 1 | Host clear: invalidates all slots and resets the pointer |
| rd_idx_i | input | PTR_W | Slot index for the read port |
| rd_valid_o | output | 1 | Valid flag of the addressed slot |
| rd_id_o | output | ID_W | Event code of the addressed slot |
| rd_ts_o | output | TS_W | Timestamp of the addressed slot |
| wr_ptr_o | output | PTR_W | Slot that the next event will fill |

## Verification
A wrong pointer shows up on `wr_ptr_o` one cycle after the faulty edge. It also shows up later as an event stored in the wrong slot, or as an event dropped while a free slot exists. A wrong valid flag or a lost pending bit makes a slot read back with the wrong validity or the wrong code the cycle after the event should have landed. Timestamp errors show as stored values that differ from the edge count since reset. The bench compares every read slot against such an edge count. It covers the wrap point, the full-log drop, a clear that collides with an event, and the saturated counter.

// File: rtl/fel_pkg.sv
package fel_pkg;
  localparam int ID_W = 4;
  localparam int TS_W = 8;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic [TS_W-1:0] ts;
  } fel_entry_t;
endpackage

// File: rtl/fel_ts_cnt.sv
module fel_ts_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] ts_o
);
  logic [W-1:0] ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ts_q <= '0;
    else if (ts_q != '1)  ts_q <= ts_q + 1'b1;  // saturate
  end

  assign ts_o = ts_q;
endmodule

// File: rtl/fel_evt_arb.sv
module fel_evt_arb #(
  parameter int N     = 3,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     evt_i,
  input  logic             hold_i,
  output logic             gnt_vld_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic [N-1:0] pend_q, req, gnt_oh;
  logic         found;

  assign req = pend_q | evt_i;

  always_comb begin
    gnt_idx_o = '0;
    gnt_oh    = '0;
    found     = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt_idx_o = IDX_W'(i);
        gnt_oh[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  assign gnt_vld_o = found && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= '0;
    else if (hold_i) pend_q <= req;
    else             pend_q <= req & ~gnt_oh;
  end
endmodule

// File: rtl/fel_store.sv
module fel_store
  import fel_pkg::*;
#(
  parameter int DEPTH = 7,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_req_i,
  input  fel_entry_t       wr_data_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output fel_entry_t       rd_entry_o,
  output logic             rd_valid_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [DEPTH-1:0] valid_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  fel_entry_t       mem_q [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [PTR_W-1:0] ptr_q;
  logic             slot_free, wr_en;

  always_comb begin
    slot_free = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (ptr_q == PTR_W'(i)) slot_free = !valid_q[i];
  end

  assign wr_en = wr_req_i && slot_free && !clr_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        mem_q[g]   <= '0;
      end else if (clr_i) begin
        valid_q[g] <= 1'b0;
      end else if (wr_en && ptr_q == PTR_W'(g)) begin
        valid_q[g] <= 1'b1;
        mem_q[g]   <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (clr_i) ptr_q <= '0;
    else if (wr_en) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    rd_entry_o = '0;
    rd_valid_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_i == PTR_W'(i) && valid_q[i]) begin
        rd_entry_o = mem_q[i];
        rd_valid_o = 1'b1;
      end
    end
  end

  assign ptr_o   = ptr_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/fault_event_log.sv
module fault_event_log
  import fel_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int DEPTH   = 7,
  parameter int PTR_W   = $clog2(DEPTH + 1),
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               clr_i,
  input  logic [PTR_W-1:0]   rd_idx_i,
  output logic               rd_valid_o,
  output logic [ID_W-1:0]    rd_id_o,
  output logic [TS_W-1:0]    rd_ts_o,
  output logic [PTR_W-1:0]   wr_ptr_o
);
  logic [TS_W-1:0]  ts_w;
  logic             gnt_vld;
  logic [IDX_W-1:0] gnt_idx;
  fel_entry_t       wr_data, rd_entry;
  logic [DEPTH-1:0] valid_w;

  fel_ts_cnt #(.W(TS_W)) u_ts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ts_o  (ts_w)
  );

  fel_evt_arb #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .hold_i   (clr_i),
    .gnt_vld_o(gnt_vld),
    .gnt_idx_o(gnt_idx)
  );

  // source k -> code k+1, code 0 reserved for empty
  assign wr_data.id = ID_W'(gnt_idx) + ID_W'(1);
  assign wr_data.ts = ts_w;

  fel_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .wr_req_i  (gnt_vld),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx_i),
    .rd_entry_o(rd_entry),
    .rd_valid_o(rd_valid_o),
    .ptr_o     (wr_ptr_o),
    .valid_o   (valid_w)
  );

  assign rd_id_o = rd_entry.id;
  assign rd_ts_o = rd_entry.ts;
endmodule

// File: rtl/fault_event_log_chk.sv
module fault_event_log_chk
  import fel_pkg::*;
#(
  parameter int DEPTH = 7,
  parameter int PTR_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic [PTR_W-1:0] wr_ptr_o,
  input logic [DEPTH-1:0] valid_w,
  input logic [TS_W-1:0]  ts_w
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic slot_busy;
  always_comb begin
    slot_busy = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (wr_ptr_o == PTR_W'(i)) slot_busy = valid_w[i];
  end

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && wr_ptr_o != LAST) |=> (wr_ptr_o == $past(wr_ptr_o) || wr_ptr_o == $past(wr_ptr_o) + 1'b1)); // R3
  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && wr_ptr_o == LAST) |=> (wr_ptr_o == LAST || wr_ptr_o == '0)); // R3
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && slot_busy) |=> $stable(wr_ptr_o)); // R4
  AST_NO_INVALIDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (($past(valid_w) & ~valid_w) == '0)); // R4
  AST_ONE_PER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ($countones(valid_w & ~$past(valid_w)) <= 1)); // R5
  AST_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (wr_ptr_o == '0 && valid_w == '0)); // R6
  AST_TS_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_w == '1) |=> (ts_w == '1)); // R7
endmodule

bind fault_event_log fault_event_log_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_i   (clr_i),
  .wr_ptr_o(wr_ptr_o),
  .valid_w (valid_w),
  .ts_w    (ts_w)
);

// File: tb/fault_event_log_bench.sv
`timescale 1ns/1ps
module fault_event_log_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] evt = '0;
  logic       clr = 1'b0;
  logic [2:0] rd_idx = '0;
  logic       rd_valid;
  logic [3:0] rd_id;
  logic [7:0] rd_ts;
  logic [2:0] wr_ptr;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int ts_slot0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  fault_event_log u_fault_event_log (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .clr_i(clr),
    .rd_idx_i(rd_idx), .rd_valid_o(rd_valid), .rd_id_o(rd_id),
    .rd_ts_o(rd_ts), .wr_ptr_o(wr_ptr)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_slot(input string tag, input int idx, input int v, input int id, input int ts);
    rd_idx = 3'(idx);
    #0.5;
    check({tag, " valid"}, int'(rd_valid), v);
    check({tag, " id"}, int'(rd_id), id);
    check({tag, " ts"}, int'(rd_ts), ts);
  endtask

  // drive one event at a negedge, return its expected timestamp
  task automatic raise(input logic [2:0] v, output int ts);
    @(negedge clk);
    evt = v;
    ts = cyc;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset;
    check("R1 ptr", int'(wr_ptr), 0);
    for (int i = 0; i < 7; i++) check_slot("R1 slot", i, 0, 0, 0);
  endtask

  task automatic t_single;
    raise(3'b001, ts_slot0);
    check_slot("R2 slot0", 0, 1, 1, ts_slot0);
    check("R3 ptr step", int'(wr_ptr), 1);
  endtask

  task automatic t_simul;
    int ts;
    raise(3'b110, ts);
    @(negedge clk);
    check_slot("R5 first", 1, 1, 2, ts);
    check_slot("R5 second", 2, 1, 3, ts + 1);
    check("R5 ptr", int'(wr_ptr), 3);
  endtask

  task automatic t_fill_wrap;
    int ts;
    for (int i = 3; i < 7; i++) begin
      raise(3'b010, ts);
      check_slot("R3 fill", i, 1, 2, ts);
    end
    check("R3 wrap", int'(wr_ptr), 0);
    raise(3'b100, ts);
    @(negedge clk);
    check("R4 ptr held", int'(wr_ptr), 0);
    check_slot("R4 slot0 kept", 0, 1, 1, ts_slot0);
    check_slot("R8 out of range", 7, 0, 0, 0);
  endtask

  task automatic t_clear;
    int ts;
    @(negedge clk);
    clr = 1'b1;
    evt = 3'b100;
    @(negedge clk);
    clr = 1'b0;
    evt = '0;
    ts = cyc;
    check("R6 ptr", int'(wr_ptr), 0);
    for (int i = 0; i < 7; i++) check_slot("R6 cleared", i, 0, 0, 0);
    @(negedge clk);
    check_slot("R6 held event", 0, 1, 3, ts);
    check("R6 ptr after", int'(wr_ptr), 1);
  endtask

  task automatic t_sat;
    int ts;
    while (cyc < 300) @(negedge clk);
    raise(3'b001, ts);
    check_slot("R7 saturated", 1, 1, 1, 255);
    check("R3 ptr", int'(wr_ptr), 2);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_single;
    t_simul;
    t_fill_wrap;
    t_clear;
    t_sat;
    finish_run;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run;
  end
endmodule